// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupt Detection

This block is a register-mapped general purpose pin controller for up to sixteen pins (twelve by default, set by `PIN_CNT`). Each pin has an output data bit, a direction bit and an input readback that passes through a two-flop synchroniser. Each pin also has an interrupt detector. Software picks one of five trigger modes for it: falling edge, rising edge, both edges, low level or high level. Per-pin enable, mask and pending bits combine into one registered interrupt output.

Software reaches the controller through a 32-bit register port. A single-cycle write strobe carries a word address (byte offset divided by four) and data. A read strobe loads the addressed word into a registered read-data output, which is valid one cycle later. A soft-reset register holds every other register at its reset value until software releases it. A plain selection register is kept for software and has no effect on the pins.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the enable, pending, output data, direction, trigger-mode, selection and soft-reset registers read zero, the mask at byte offset 0x10 reads all ones over the pin bits, `irq_out` is 0 and `pin_oe` and `pin_out` are 0.
- R2: Output data (byte offset 0x18) drives `pin_out` and direction (0x20) drives `pin_oe`, where a 1 means the pin is driven. Both read back what was written. Bits at or above `PIN_CNT` read zero and ignore writes.
- R3: Input data (0x1C) returns the pin levels after a two-flop synchroniser. It is read-only, and a pin change shows up in a read issued two cycles after the change.
- R4: Pin n keeps a 3-bit trigger code in bits [4*(n mod 8)+2 : 4*(n mod 8)] of the word at 0x24 (pins 0 to 7) or 0x28 (pins 8 to 15). Bit 3 of each nibble, and the nibbles of absent pins, read zero.
- R5: Code 0 sets a pin's pending bit on a falling edge, code 1 on a rising edge and code 4 on either edge. An edge sets the bit once, and a transition in a direction the code does not select sets nothing.
- R6: Code 2 (low level) and code 3 (high level) set the pending bit in every cycle the level lasts, so a clear written while the level lasts has no visible effect.
- R7: Codes 5, 6 and 7 never set the pending bit.
- R8: A pending bit sets only while the pin's bit in the enable register (0x00) is 1.
- R9: Writing 1s to 0x10 sets those mask bits, and writing 1s to 0x14 clears them. Zero bits leave the mask unchanged, and reading 0x10 returns the mask.
- R10: Writing 1s to 0x0C clears those pending bits, and zero bits have no effect. A detection in the same cycle as the clear wins, so the bit stays set.
- R11: 0x08 reads the raw pending bits and 0x04 reads the pending bits with masked pins removed. `irq_out` is the OR of the unmasked pending bits, registered one cycle after them.
- R12: Writing 1 to bit 0 of 0x3C holds every other register and the detectors at their reset values and ignores writes to them. Writing 0 releases them so that they can be written again. Bit 0 of 0x3C reads back the hold state.
- R13: The selection register at 0x38 stores `PIN_CNT` bits that read back and affect nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, loads bus_rdata at the edge |
| bus_addr | input | 4 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | PIN_CNT | Asynchronous pin levels |
| pin_out | output | PIN_CNT | Output data to the pins |
| pin_oe | output | PIN_CNT | Output enable per pin, 1 = driven |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
A write to the pending-clear register and a new detection on the same pin can land on the same clock edge. The bench provokes this by raising a pin under rising-edge mode and issuing the clear write exactly two cycles after the change, which is the edge where the detection registers. It judges the outcome by reading the raw pending register, which must still show the bit. A level-mode pin gives the same collision on every cycle. Here a clear during a held level must leave the bit set, while a clear after the level ends must drop it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned ADDR_W     = 4;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned TRIG_W     = 3;
  localparam int unsigned NIBBLE_W   = 4;
  localparam int unsigned MAX_PINS   = 16;

  // Word addresses; software computes them as byte offset / 4.
  localparam logic [ADDR_W-1:0] A_ENABLE  = 4'h0;
  localparam logic [ADDR_W-1:0] A_STATUS  = 4'h1;
  localparam logic [ADDR_W-1:0] A_DISPLAY = 4'h2;
  localparam logic [ADDR_W-1:0] A_CLEAR   = 4'h3;
  localparam logic [ADDR_W-1:0] A_MSET    = 4'h4;
  localparam logic [ADDR_W-1:0] A_MCLR    = 4'h5;
  localparam logic [ADDR_W-1:0] A_OUT     = 4'h6;
  localparam logic [ADDR_W-1:0] A_IN      = 4'h7;
  localparam logic [ADDR_W-1:0] A_DIR     = 4'h8;
  localparam logic [ADDR_W-1:0] A_MODE0   = 4'h9;
  localparam logic [ADDR_W-1:0] A_MODE1   = 4'hA;
  localparam logic [ADDR_W-1:0] A_USESEL  = 4'hE;
  localparam logic [ADDR_W-1:0] A_SRST    = 4'hF;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_FALL = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_HIGH = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  // Detection for one pin from its current and previous synchronised sample.
  function automatic logic trig_hit(input logic [TRIG_W-1:0] code,
                                    input logic cur, input logic prev);
    logic h;
    case (code)
      TRIG_FALL: h = prev & ~cur;
      TRIG_RISE: h = ~prev & cur;
      TRIG_LOW:  h = ~cur;
      TRIG_HIGH: h = cur;
      TRIG_BOTH: h = prev ^ cur;
      default:   h = 1'b0;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);

  logic [W-1:0] meta_q;
  logic [W-1:0] cur_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;

endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              clr,
  input  logic [TRIG_W-1:0] code,
  input  logic              cur,
  input  logic              prev,
  output logic              hit,
  output logic              pend
);

  logic pend_q;

  assign hit = trig_hit(code, cur, prev);

  // A new detection takes priority over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)
      pend_q <= 1'b0;
    else if (hit && en)
      pend_q <= 1'b1;
    else if (clr)
      pend_q <= 1'b0;
  end

  assign pend = pend_q;

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PIN_CNT = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [PIN_CNT-1:0]        en_q,
  output logic [PIN_CNT-1:0]        mask_q,
  output logic [PIN_CNT-1:0]        out_q,
  output logic [PIN_CNT-1:0]        dir_q,
  output logic [PIN_CNT-1:0]        usesel_q,
  output logic [PIN_CNT*TRIG_W-1:0] mode_flat,
  output logic [PIN_CNT-1:0]        clr_bits
);

  localparam int unsigned PER_WORD = DATA_W / NIBBLE_W;

  logic [PIN_CNT-1:0] wbits;
  logic               unused_wdata;

  assign wbits        = wdata[PIN_CNT-1:0];
  assign unused_wdata = ^wdata;

  function automatic logic sel(input logic [ADDR_W-1:0] a);
    return wr && (addr == a);
  endfunction

  assign clr_bits = sel(A_CLEAR) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      mask_q   <= '1;
      out_q    <= '0;
      dir_q    <= '0;
      usesel_q <= '0;
    end else begin
      if (sel(A_ENABLE)) en_q     <= wbits;
      if (sel(A_OUT))    out_q    <= wbits;
      if (sel(A_DIR))    dir_q    <= wbits;
      if (sel(A_USESEL)) usesel_q <= wbits;
      if (sel(A_MSET))
        mask_q <= mask_q | wbits;
      else if (sel(A_MCLR))
        mask_q <= mask_q & ~wbits;
    end
  end

  for (genvar n = 0; n < PIN_CNT; n++) begin : g_mode
    localparam logic [ADDR_W-1:0] W_ADDR = (n < PER_WORD) ? A_MODE0 : A_MODE1;
    localparam int unsigned       LSB    = NIBBLE_W * (n % PER_WORD);
    logic [TRIG_W-1:0] code_q;

    always_ff @(posedge clk) begin
      if (rst)
        code_q <= '0;
      else if (sel(W_ADDR))
        code_q <= wdata[LSB +: TRIG_W];
    end

    assign mode_flat[TRIG_W*n +: TRIG_W] = code_q;
  end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PIN_CNT = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [3:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [PIN_CNT-1:0] pin_in,
  output logic [PIN_CNT-1:0] pin_out,
  output logic [PIN_CNT-1:0] pin_oe,
  output logic               irq_out
);

  localparam int unsigned MODE_CAT_W = MAX_PINS * NIBBLE_W;

  logic                      soft_q;
  logic                      core_rst;
  logic [PIN_CNT-1:0]        en_q, mask_q, out_q, dir_q, usesel_q, clr_bits;
  logic [PIN_CNT*TRIG_W-1:0] mode_flat;
  logic [PIN_CNT-1:0]        cur_vec, prev_vec, hit_vec, pend_vec;
  logic [PIN_CNT-1:0]        live_vec;
  logic [MODE_CAT_W-1:0]     mode_cat;
  logic [31:0]               rd_mux;
  logic [31:0]               rdata_q;
  logic                      irq_q;

  // Soft-reset hold bit answers only to the hard reset.
  always_ff @(posedge clk) begin
    if (rst)
      soft_q <= 1'b0;
    else if (bus_wr && bus_addr == A_SRST)
      soft_q <= bus_wdata[0];
  end

  assign core_rst = rst | soft_q;

  gpio_cfg_regs #(.PIN_CNT(PIN_CNT)) u_cfg (
    .clk       (clk),
    .rst       (core_rst),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .en_q      (en_q),
    .mask_q    (mask_q),
    .out_q     (out_q),
    .dir_q     (dir_q),
    .usesel_q  (usesel_q),
    .mode_flat (mode_flat),
    .clr_bits  (clr_bits)
  );

  gpio_in_sync #(.W(PIN_CNT)) u_sync (
    .clk  (clk),
    .rst  (core_rst),
    .d    (pin_in),
    .cur  (cur_vec),
    .prev (prev_vec)
  );

  for (genvar n = 0; n < PIN_CNT; n++) begin : g_pin
    gpio_pin_detect u_det (
      .clk  (clk),
      .rst  (core_rst),
      .en   (en_q[n]),
      .clr  (clr_bits[n]),
      .code (mode_flat[TRIG_W*n +: TRIG_W]),
      .cur  (cur_vec[n]),
      .prev (prev_vec[n]),
      .hit  (hit_vec[n]),
      .pend (pend_vec[n])
    );
  end

  assign live_vec = pend_vec & ~mask_q;

  always_comb begin
    mode_cat = '0;
    for (int n = 0; n < PIN_CNT; n++)
      mode_cat[NIBBLE_W*n +: TRIG_W] = mode_flat[TRIG_W*n +: TRIG_W];
  end

  always_comb begin
    case (bus_addr)
      A_ENABLE:  rd_mux = 32'(en_q);
      A_STATUS:  rd_mux = 32'(live_vec);
      A_DISPLAY: rd_mux = 32'(pend_vec);
      A_MSET:    rd_mux = 32'(mask_q);
      A_OUT:     rd_mux = 32'(out_q);
      A_IN:      rd_mux = 32'(cur_vec);
      A_DIR:     rd_mux = 32'(dir_q);
      A_MODE0:   rd_mux = mode_cat[31:0];
      A_MODE1:   rd_mux = mode_cat[63:32];
      A_USESEL:  rd_mux = 32'(usesel_q);
      A_SRST:    rd_mux = {31'b0, soft_q};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else if (bus_rd)
      rdata_q <= rd_mux;
  end

  always_ff @(posedge clk) begin
    if (core_rst)
      irq_q <= 1'b0;
    else
      irq_q <= |live_vec;
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;
  assign pin_out   = out_q;
  assign pin_oe    = dir_q;

endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
  import gpio_irq_pkg::*;
#(
  parameter int unsigned PIN_CNT = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               soft_q,
  input logic               wr_en,
  input logic [3:0]         addr,
  input logic [31:0]        wdata,
  input logic [PIN_CNT-1:0] pend,
  input logic [PIN_CNT-1:0] en_q,
  input logic [PIN_CNT-1:0] mask_q,
  input logic [PIN_CNT-1:0] hit,
  input logic [PIN_CNT-1:0] pin_oe,
  input logic               irq_out
);

  logic [PIN_CNT-1:0] wbits;
  logic               unused_wdata;

  assign wbits        = wdata[PIN_CNT-1:0];
  assign unused_wdata = ^wdata;

  assert_irq_follows_R11: assert property (@(posedge clk) disable iff (rst || soft_q)
    (|(pend & ~mask_q)) |=> irq_out);

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (rst || soft_q)
    !(|(pend & ~mask_q)) |=> !irq_out);

  assert_set_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
    (pend & ~$past(pend) & ~$past(en_q)) == '0);

  assert_clear_drops_R10: assert property (@(posedge clk) disable iff (rst || soft_q)
    (wr_en && addr == A_CLEAR) |=> ((pend & $past(wbits & ~(hit & en_q))) == '0));

  assert_mask_set_R9: assert property (@(posedge clk) disable iff (rst || soft_q)
    (wr_en && addr == A_MSET) |=> ((mask_q & $past(wbits)) == $past(wbits)));

  assert_mask_clear_R9: assert property (@(posedge clk) disable iff (rst || soft_q)
    (wr_en && addr == A_MCLR) |=> ((mask_q & $past(wbits)) == '0));

  assert_dir_to_pins_R2: assert property (@(posedge clk) disable iff (rst || soft_q)
    (wr_en && addr == A_DIR) |=> (pin_oe == $past(wbits)));

  assert_soft_hold_R12: assert property (@(posedge clk) disable iff (rst)
    soft_q |=> (pend == '0 && pin_oe == '0 && mask_q == '1 && !irq_out));

endmodule

bind gpio_irq_ctrl gpio_irq_checker #(.PIN_CNT(PIN_CNT)) u_checker (
  .clk     (clk),
  .rst     (rst),
  .soft_q  (soft_q),
  .wr_en   (bus_wr),
  .addr    (bus_addr),
  .wdata   (bus_wdata),
  .pend    (pend_vec),
  .en_q    (en_q),
  .mask_q  (mask_q),
  .hit     (hit_vec),
  .pin_oe  (pin_oe),
  .irq_out (irq_out)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int P = 12;

  localparam logic [3:0] W_EN = 4'h0, W_STAT = 4'h1, W_DISP = 4'h2, W_CLR = 4'h3;
  localparam logic [3:0] W_MSET = 4'h4, W_MCLR = 4'h5, W_OUT = 4'h6, W_IN = 4'h7;
  localparam logic [3:0] W_DIR = 4'h8, W_MD0 = 4'h9, W_MD1 = 4'hA, W_SEL = 4'hE;
  localparam logic [3:0] W_SRST = 4'hF;

  // {word address, write data, expected readback, requirement number}
  localparam logic [71:0] VEC [0:9] = '{
    {W_OUT,  32'hFFFF_FFFF, 32'h0000_0FFF, 4'd2},   // R2 upper bits dropped
    {W_OUT,  32'h0000_0A5A, 32'h0000_0A5A, 4'd2},   // R2
    {W_DIR,  32'hFFFF_0F0F, 32'h0000_0F0F, 4'd2},   // R2
    {W_DIR,  32'h0000_0000, 32'h0000_0000, 4'd2},   // R2
    {W_MD0,  32'hFFFF_FFFF, 32'h7777_7777, 4'd4},   // R4 bit 3 of nibble reserved
    {W_MD1,  32'hFFFF_FFFF, 32'h0000_7777, 4'd4},   // R4 absent pins read zero
    {W_MD0,  32'h1234_5678, 32'h1234_5670, 4'd4},   // R4
    {W_SEL,  32'hFFFF_FFFF, 32'h0000_0FFF, 4'd13},  // R13
    {W_EN,   32'hABCD_E123, 32'h0000_0123, 4'd8},   // R8 enable readback
    {W_IN,   32'hFFFF_FFFF, 32'h0000_0000, 4'd3}    // R3 read-only
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           bus_wr = 1'b0;
  logic           bus_rd = 1'b0;
  logic [3:0]     bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [P-1:0]   pin_in = '0;
  logic [P-1:0]   pin_out;
  logic [P-1:0]   pin_oe;
  logic           irq_out;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl #(.PIN_CNT(P)) i_gpio_irq_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input string what,
                        input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, what, v, exp);
  endtask

  task automatic set_pins(input logic [P-1:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic hard_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    hard_reset();

    // Vector table: write then read back.
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][71:68], VEC[i][67:36]);
      rd(VEC[i][71:68], v);
      check($sformatf("R%0d", VEC[i][3:0]), $sformatf("vector %0d", i), v, VEC[i][35:4]);
    end

    hard_reset();
    // R1 reset values
    rd_chk("R1", "mask", W_MSET, 32'hFFF);
    rd_chk("R1", "enable", W_EN, 32'h0);
    rd_chk("R1", "out", W_OUT, 32'h0);
    rd_chk("R1", "dir", W_DIR, 32'h0);
    rd_chk("R1", "mode0", W_MD0, 32'h0);
    rd_chk("R1", "mode1", W_MD1, 32'h0);
    rd_chk("R1", "sel", W_SEL, 32'h0);
    rd_chk("R1", "srst", W_SRST, 32'h0);
    rd_chk("R1", "display", W_DISP, 32'h0);
    check("R1", "irq_out", {31'b0, irq_out}, 32'h0);
    check("R1", "pin_oe", 32'(pin_oe), 32'h0);
    check("R1", "pin_out", 32'(pin_out), 32'h0);

    // R3 synchroniser latency
    @(negedge clk);
    pin_in = 12'h5A5;
    rd_chk("R3", "input before sync", W_IN, 32'h0);
    rd_chk("R3", "input after sync", W_IN, 32'h5A5);
    rd_chk("R8", "no pend while disabled", W_DISP, 32'h0);

    // R5 falling edge on pin 0 (code 0) and irq timing R11
    wr(W_EN, 32'h1);
    wr(W_MCLR, 32'h1);
    @(negedge clk);
    pin_in[0] = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", "irq not yet", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R11", "irq one cycle after pend", {31'b0, irq_out}, 32'h1);
    rd_chk("R5", "falling edge pend", W_DISP, 32'h1);
    rd_chk("R11", "status unmasked", W_STAT, 32'h1);
    wr(W_CLR, 32'h1);
    rd_chk("R10", "clear", W_DISP, 32'h0);
    check("R11", "irq drops", {31'b0, irq_out}, 32'h0);

    // R5 rising edge (code 1)
    wr(W_MD0, 32'h1);
    set_pins(12'h5A5);
    rd_chk("R5", "rising edge pend", W_DISP, 32'h1);
    wr(W_CLR, 32'h1);
    set_pins(12'h5A4);
    rd_chk("R5", "falling ignored in rising mode", W_DISP, 32'h0);

    // R5 both edges (code 4)
    wr(W_MD0, 32'h4);
    set_pins(12'h5A5);
    rd_chk("R5", "both: rise", W_DISP, 32'h1);
    wr(W_CLR, 32'h1);
    rd_chk("R5", "both: single set per edge", W_DISP, 32'h0);
    set_pins(12'h5A4);
    rd_chk("R5", "both: fall", W_DISP, 32'h1);
    wr(W_CLR, 32'h1);

    // R6 level high (code 3)
    wr(W_MD0, 32'h3);
    rd_chk("R6", "high mode, pin low", W_DISP, 32'h0);
    set_pins(12'h5A5);
    rd_chk("R6", "high level pend", W_DISP, 32'h1);
    wr(W_CLR, 32'h1);
    rd_chk("R6", "clear during level reasserts", W_DISP, 32'h1);
    set_pins(12'h5A4);
    wr(W_CLR, 32'h1);
    rd_chk("R6", "clear after level ends", W_DISP, 32'h0);

    // R6 level low (code 2) on pin 9, field in word 0x28 bits [6:4] (R4)
    wr(W_EN, 32'h201);
    wr(W_MCLR, 32'h200);
    wr(W_MD1, 32'h20);
    repeat (2) @(negedge clk);
    rd_chk("R6", "low level pin 9", W_DISP, 32'h200);
    check("R11", "irq from pin 9", {31'b0, irq_out}, 32'h1);
    set_pins(12'h7A4);
    wr(W_CLR, 32'h200);
    rd_chk("R6", "low level ended", W_DISP, 32'h0);

    // R7 unused codes 5..7
    for (int m = 5; m < 8; m++) begin
      wr(W_MD0, 32'(m));
      wr(W_CLR, 32'hFFF);
      set_pins(12'h7A5);
      rd_chk("R7", $sformatf("code %0d rise/high", m), W_DISP, 32'h0);
      set_pins(12'h7A4);
      rd_chk("R7", $sformatf("code %0d fall/low", m), W_DISP, 32'h0);
    end

    // R8 enable gate
    wr(W_EN, 32'h0);
    wr(W_MD0, 32'h3);
    set_pins(12'h7A5);
    rd_chk("R8", "level held but disabled", W_DISP, 32'h0);
    wr(W_EN, 32'h1);
    rd_chk("R8", "enable lets level set", W_DISP, 32'h1);

    // R9 mask set/clear, R11 status vs display
    rd_chk("R9", "mask after clears", W_MSET, 32'hDFE);
    wr(W_MSET, 32'h1);
    rd_chk("R9", "mask set bit 0", W_MSET, 32'hDFF);
    rd_chk("R11", "status masked", W_STAT, 32'h0);
    rd_chk("R11", "display raw", W_DISP, 32'h1);
    check("R11", "irq masked", {31'b0, irq_out}, 32'h0);
    wr(W_MSET, 32'h0);
    rd_chk("R9", "zero set no change", W_MSET, 32'hDFF);
    wr(W_MCLR, 32'h0);
    rd_chk("R9", "zero clear no change", W_MSET, 32'hDFF);
    wr(W_MCLR, 32'h1);
    rd_chk("R9", "mask clear bit 0", W_MSET, 32'hDFE);
    rd_chk("R11", "status unmasked again", W_STAT, 32'h1);
    check("R11", "irq unmasked", {31'b0, irq_out}, 32'h1);

    // R10 clear with zero bits, then clear colliding with detection
    wr(W_MD0, 32'h1);
    wr(W_CLR, 32'h0);
    rd_chk("R10", "zero clear keeps pend", W_DISP, 32'h1);
    wr(W_CLR, 32'h2);
    rd_chk("R10", "other bit clear keeps pend", W_DISP, 32'h1);
    wr(W_CLR, 32'h1);
    rd_chk("R10", "own bit clear", W_DISP, 32'h0);
    set_pins(12'h7A4);
    @(negedge clk);
    pin_in[0] = 1'b1;
    @(negedge clk);
    wr(W_CLR, 32'h1);
    rd_chk("R10", "detection wins over same-cycle clear", W_DISP, 32'h1);

    // R12 soft reset
    wr(W_OUT, 32'hFFF);
    wr(W_DIR, 32'hFFF);
    check("R2", "pin_oe driven", 32'(pin_oe), 32'hFFF);
    check("R2", "pin_out driven", 32'(pin_out), 32'hFFF);
    wr(W_SRST, 32'h1);
    @(negedge clk);
    check("R12", "pin_oe held", 32'(pin_oe), 32'h0);
    check("R12", "pin_out held", 32'(pin_out), 32'h0);
    check("R12", "irq held", {31'b0, irq_out}, 32'h0);
    rd_chk("R12", "srst reads 1", W_SRST, 32'h1);
    wr(W_OUT, 32'h123);
    rd_chk("R12", "write ignored in hold", W_OUT, 32'h0);
    rd_chk("R12", "mask reset in hold", W_MSET, 32'hFFF);
    rd_chk("R12", "pend reset in hold", W_DISP, 32'h0);
    wr(W_SRST, 32'h0);
    rd_chk("R12", "srst released", W_SRST, 32'h0);
    rd_chk("R12", "out still reset", W_OUT, 32'h0);
    wr(W_OUT, 32'h3C3);
    rd_chk("R12", "rewrite after release", W_OUT, 32'h3C3);
    check("R12", "pin_out after release", 32'(pin_out), 32'h3C3);
    wr(W_EN, 32'h1);
    rd_chk("R12", "enable rewrite", W_EN, 32'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule